// File: doc/BRIEF.md
# Write Completion Status Reporter

This block sits on the read path of a page-programmed non-volatile memory. While the write logic runs an internal program or erase cycle, the array cannot be read. The block substitutes a status byte for the array data, so that the host can poll for the end of the cycle. Once the cycle ends, reads return array data again. The output is a plain registered data bus with a valid flag. Bus tristate and analog output timing belong elsewhere.

The status byte carries two independent completion indicators. The first is a polled bit: for the last loaded address it shows the inverse of the value that the bit will hold once the cycle is done. The second is a toggle bit that inverts on every qualified read while the cycle runs. The write logic supplies the busy flag, the cycle kind, the last loaded address and the true value of the polled bit of the last loaded byte. The block latches these when busy rises. The host supplies a read strobe with select, output-enable and write-enable levels.

Top module: `wcs_status_reporter`

## Requirements
- R1: While reset is held and right after it, rd_valid is 0 and rd_data is all zeros.
- R2: A read is qualified only when host_req, host_sel and host_oe are 1 and host_we is 0. A qualified read in one cycle makes rd_valid 1 exactly one clock later. Any other combination leaves rd_valid at 0.
- R3: A qualified read taken while wr_busy is 0 returns arr_rdata as it was in the strobe cycle.
- R4: During a program cycle (wr_erase 0 at the start), a qualified read at the latched last address returns bit POLL_BIT (default 7) as the inverse of the latched wr_last_msb.
- R5: During a program cycle, a qualified read at any other address returns bit POLL_BIT as 0.
- R6: During a cycle, bit TOGGLE_BIT (default 6) is 0 on the first qualified read. It is inverted on each following qualified read.
- R7: Strobes that are not qualified do not advance the toggle bit. The next qualified read shows the value it would have shown without them.
- R8: Each rising edge of wr_busy starts a new cycle with the toggle bit at 0, even when the previous cycle ended with it at 1. A read taken in that same clock already sees the new cycle.
- R9: During an erase cycle (wr_erase 1 at the start), bit POLL_BIT reads 0 at every address.
- R10: During a cycle, all bits other than POLL_BIT and TOGGLE_BIT read 0, whatever arr_rdata holds.
- R11: The address, polled-bit value and cycle kind are taken at the rising edge of wr_busy. Changes to wr_last_addr, wr_last_msb or wr_erase later in the cycle have no effect on its status reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_busy | input | 1 | Internal program or erase cycle running |
| wr_erase | input | 1 | Cycle being started is an erase (1) or a program (0) |
| wr_last_addr | input | ADDR_W | Address of the last loaded byte |
| wr_last_msb | input | 1 | True value of the polled bit of the last loaded byte |
| host_req | input | 1 | Host read strobe, one cycle per access |
| host_sel | input | 1 | Chip selected (active high) |
| host_oe | input | 1 | Output enable asserted (active high) |
| host_we | input | 1 | Write enable asserted (active high) |
| host_addr | input | ADDR_W | Read address |
| arr_rdata | input | DATA_W | Array data at host_addr |
| rd_data | output | DATA_W | Registered read data or status byte |
| rd_valid | output | 1 | rd_data holds the result of a qualified read |

## Verification
The bench builds the block with ADDR_W = 6 and DATA_W = 8. With the narrow address, random reads hit the latched last address often, so both the inverted polled bit and the zero on other addresses occur many times in every cycle. Busy edges, cycle kinds and strobe qualifiers are drawn at random, so reads that land in the same clock as a busy rise and unqualified strobes in the middle of a cycle occur many times. The directed part forces the toggle restart, the input changes in the middle of a cycle and an all-ones array word behind a status read.

// File: rtl/wcs_pkg.sv
package wcs_pkg;
  typedef enum logic {
    CYC_PROGRAM = 1'b0,
    CYC_ERASE   = 1'b1
  } cyc_kind_t;

  function automatic cyc_kind_t kind_of(input logic erase_flag);
    return erase_flag ? CYC_ERASE : CYC_PROGRAM;
  endfunction
endpackage

// File: rtl/wcs_read_qual.sv
module wcs_read_qual (
  input  logic host_req,
  input  logic host_sel,
  input  logic host_oe,
  input  logic host_we,
  output logic rd_fire
);
  function automatic logic qualify(input logic req, input logic sel,
                                   input logic oe, input logic we);
    return req & sel & oe & ~we;
  endfunction

  assign rd_fire = qualify(host_req, host_sel, host_oe, host_we);
endmodule

// File: rtl/wcs_cycle_track.sv
module wcs_cycle_track
  import wcs_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              erase_in,
  input  logic [ADDR_W-1:0] last_addr_in,
  input  logic              last_msb_in,
  input  logic              rd_fire,
  output logic              start_ev,
  output logic              rd_busy_ev,
  output logic [ADDR_W-1:0] ref_addr,
  output logic              ref_msb,
  output cyc_kind_t         ref_kind,
  output logic              tog_now
);
  logic              busy_q;
  logic [ADDR_W-1:0] addr_q;
  logic              msb_q;
  cyc_kind_t         kind_q;
  logic              tog_q;
  logic              tog_d;

  assign start_ev   = busy & ~busy_q;
  assign rd_busy_ev = rd_fire & busy;

  assign ref_addr = start_ev ? last_addr_in : addr_q;
  assign ref_msb  = start_ev ? last_msb_in  : msb_q;
  assign ref_kind = start_ev ? kind_of(erase_in) : kind_q;
  assign tog_now  = start_ev ? 1'b0 : tog_q;

  always_comb begin
    tog_d = tog_q;
    if (rd_busy_ev)    tog_d = ~tog_now;
    else if (start_ev) tog_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      addr_q <= '0;
      msb_q  <= 1'b0;
      kind_q <= CYC_PROGRAM;
      tog_q  <= 1'b0;
    end else begin
      busy_q <= busy;
      tog_q  <= tog_d;
      if (start_ev) begin
        addr_q <= last_addr_in;
        msb_q  <= last_msb_in;
        kind_q <= kind_of(erase_in);
      end
    end
  end

  AST_TOGGLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_busy_ev && !start_ev) |=> $stable(tog_q)); // R7
  AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_busy_ev && !start_ev) |=> (tog_q != $past(tog_q))); // R6
  AST_TOGGLE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ev && !rd_busy_ev) |=> !tog_q); // R8
  AST_LATCH_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start_ev) |-> (ref_addr == addr_q && ref_msb == msb_q)); // R11
endmodule

// File: rtl/wcs_status_mux.sv
module wcs_status_mux
  import wcs_pkg::*;
#(
  parameter int ADDR_W     = 17,
  parameter int DATA_W     = 8,
  parameter int POLL_BIT   = 7,
  parameter int TOGGLE_BIT = 6
) (
  input  logic              busy,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [ADDR_W-1:0] ref_addr,
  input  logic              ref_msb,
  input  cyc_kind_t         ref_kind,
  input  logic              tog_now,
  input  logic [DATA_W-1:0] arr_rdata,
  output logic [DATA_W-1:0] next_byte,
  output logic              poll_hit
);
  function automatic logic poll_value(input cyc_kind_t kind, input logic hit,
                                      input logic true_msb);
    if (kind == CYC_ERASE) return 1'b0;
    return hit ? ~true_msb : 1'b0;
  endfunction

  function automatic logic [DATA_W-1:0] status_byte(input logic pbit, input logic tbit);
    logic [DATA_W-1:0] s;
    s             = '0;
    s[POLL_BIT]   = pbit;
    s[TOGGLE_BIT] = tbit;
    return s;
  endfunction

  assign poll_hit  = (host_addr == ref_addr);
  assign next_byte = busy ? status_byte(poll_value(ref_kind, poll_hit, ref_msb), tog_now)
                          : arr_rdata;
endmodule

// File: rtl/wcs_status_reporter.sv
module wcs_status_reporter
  import wcs_pkg::*;
#(
  parameter int ADDR_W     = 17,
  parameter int DATA_W     = 8,
  parameter int POLL_BIT   = 7,
  parameter int TOGGLE_BIT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_busy,
  input  logic              wr_erase,
  input  logic [ADDR_W-1:0] wr_last_addr,
  input  logic              wr_last_msb,
  input  logic              host_req,
  input  logic              host_sel,
  input  logic              host_oe,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] arr_rdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  localparam logic [DATA_W-1:0] STATUS_MASK =
    (DATA_W'(1) << POLL_BIT) | (DATA_W'(1) << TOGGLE_BIT);

  logic              rd_fire;
  logic              start_ev;
  logic              rd_busy_ev;
  logic [ADDR_W-1:0] ref_addr;
  logic              ref_msb;
  cyc_kind_t         ref_kind;
  logic              tog_now;
  logic [DATA_W-1:0] next_byte;
  logic              poll_hit;
  logic [DATA_W-1:0] data_q;
  logic              valid_q;

  wcs_read_qual u_qual (
    .host_req (host_req),
    .host_sel (host_sel),
    .host_oe  (host_oe),
    .host_we  (host_we),
    .rd_fire  (rd_fire)
  );

  wcs_cycle_track #(.ADDR_W(ADDR_W)) u_track (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (wr_busy),
    .erase_in     (wr_erase),
    .last_addr_in (wr_last_addr),
    .last_msb_in  (wr_last_msb),
    .rd_fire      (rd_fire),
    .start_ev     (start_ev),
    .rd_busy_ev   (rd_busy_ev),
    .ref_addr     (ref_addr),
    .ref_msb      (ref_msb),
    .ref_kind     (ref_kind),
    .tog_now      (tog_now)
  );

  wcs_status_mux #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .POLL_BIT(POLL_BIT), .TOGGLE_BIT(TOGGLE_BIT)
  ) u_mux (
    .busy      (wr_busy),
    .host_addr (host_addr),
    .ref_addr  (ref_addr),
    .ref_msb   (ref_msb),
    .ref_kind  (ref_kind),
    .tog_now   (tog_now),
    .arr_rdata (arr_rdata),
    .next_byte (next_byte),
    .poll_hit  (poll_hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= rd_fire;
      if (rd_fire) data_q <= next_byte;
    end
  end

  assign rd_data  = data_q;
  assign rd_valid = valid_q;

  AST_VALID_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(host_req && host_sel && host_oe && !host_we)); // R2
  AST_IDLE_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !$past(wr_busy)) |-> (rd_data == $past(arr_rdata))); // R3
  AST_POLL_INVERT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past(wr_busy && ref_kind == CYC_PROGRAM && poll_hit))
      |-> (rd_data[POLL_BIT] == !$past(ref_msb))); // R4
  AST_ERASE_POLL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past(wr_busy && ref_kind == CYC_ERASE)) |-> !rd_data[POLL_BIT]); // R9
  AST_OTHER_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past(wr_busy)) |-> ((rd_data & ~STATUS_MASK) == '0)); // R10
  AST_TOGGLE_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past(wr_busy)) |-> (rd_data[TOGGLE_BIT] == $past(tog_now))); // R6
endmodule

// File: tb/wcs_status_reporter_bench.sv
`timescale 1ns/1ps
module wcs_status_reporter_bench;
  localparam int AW = 6;
  localparam int DW = 8;
  localparam int PB = 7;
  localparam int TB = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_busy = 1'b0, wr_erase = 1'b0, wr_last_msb = 1'b0;
  logic [AW-1:0] wr_last_addr = '0;
  logic          host_req = 1'b0, host_sel = 1'b0, host_oe = 1'b0, host_we = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [DW-1:0] arr_rdata = '0;
  logic [DW-1:0] rd_data;
  logic          rd_valid;

  int n_cmp = 0;
  int n_bad = 0;

  // bench model
  logic          m_prev_busy = 1'b0;
  logic          m_erase = 1'b0, m_msb = 1'b0, m_tog = 1'b0;
  logic [AW-1:0] m_addr = '0;

  always #10 clk = ~clk;

  wcs_status_reporter #(.ADDR_W(AW), .DATA_W(DW), .POLL_BIT(PB), .TOGGLE_BIT(TB))
  u_wcs_status_reporter (
    .clk(clk), .rst_n(rst_n), .wr_busy(wr_busy), .wr_erase(wr_erase),
    .wr_last_addr(wr_last_addr), .wr_last_msb(wr_last_msb),
    .host_req(host_req), .host_sel(host_sel), .host_oe(host_oe), .host_we(host_we),
    .host_addr(host_addr), .arr_rdata(arr_rdata), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  function automatic logic [DW-1:0] expect_byte(input logic busy, input logic erase,
      input logic same_addr, input logic true_msb, input logic tog, input logic [DW-1:0] arr);
    logic [DW-1:0] r;
    if (!busy) return arr;
    r = {DW{1'b0}};
    r[TB] = tog;
    r[PB] = erase ? 1'b0 : (same_addr & !true_msb);
    return r;
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // inputs are set before the call, at a falling edge; one clock is applied
  task automatic tick(input string tag);
    logic qual, start;
    logic [DW-1:0] exp;
    qual  = host_req & host_sel & host_oe & ~host_we;
    start = wr_busy & ~m_prev_busy;
    if (start) begin
      m_addr = wr_last_addr; m_msb = wr_last_msb; m_erase = wr_erase; m_tog = 1'b0;
    end
    exp = expect_byte(wr_busy, m_erase, host_addr == m_addr, m_msb, m_tog, arr_rdata);
    if (qual && wr_busy) m_tog = ~m_tog;
    m_prev_busy = wr_busy;
    @(posedge clk);
    @(negedge clk);
    check({tag, " valid"}, {{(DW-1){1'b0}}, rd_valid}, {{(DW-1){1'b0}}, qual});
    if (qual) check({tag, " data"}, rd_data, exp);
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
    host_req = 1; host_sel = 1; host_oe = 1; host_we = 0; host_addr = a; arr_rdata = d;
    tick(tag);
    host_req = 0;
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] first;
    first = 8'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1 reset valid", {{(DW-1){1'b0}}, rd_valid}, '0);
    check("R1 reset data", rd_data, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", rd_data, '0);

    rd(6'h05, 8'h3C, "R3 idle read");
    rd(6'h06, 8'hFF, "R3 idle read ff");
    host_req = 1; host_sel = 0; host_oe = 1; host_we = 0; tick("R2 not selected");
    host_sel = 1; host_oe = 0; tick("R2 output disabled");
    host_oe = 1; host_we = 1; tick("R2 write enable on");
    host_req = 0; host_we = 0; tick("R2 no strobe");

    // program cycle
    wr_busy = 1; wr_erase = 0; wr_last_addr = 6'h2A; wr_last_msb = 1;
    rd(6'h2A, 8'hFF, "R4 R6 R8 first busy read");
    rd(6'h2A, 8'hFF, "R6 R10 second busy read");
    rd(6'h11, 8'hFF, "R5 other address");
    host_req = 1; host_sel = 0; host_oe = 1; tick("R7 unqualified strobe");
    host_req = 1; host_sel = 1; host_we = 1; tick("R7 write-enabled strobe");
    host_we = 0; host_req = 0;
    wr_last_addr = 6'h01; wr_last_msb = 0; wr_erase = 1;
    rd(6'h2A, 8'hA5, "R11 R7 inputs changed mid cycle");
    rd(6'h01, 8'h5A, "R11 new input address ignored");
    wr_busy = 0;
    rd(6'h2A, 8'h77, "R3 after busy falls");
    // new cycle, toggle restarts; last one ended with toggle at 1
    wr_busy = 1; wr_erase = 0; wr_last_addr = 6'h10; wr_last_msb = 0;
    tick("R8 start without read");
    rd(6'h10, 8'h00, "R8 R4 restart at zero");
    wr_busy = 0; tick("idle");
    // erase cycle
    wr_busy = 1; wr_erase = 1; wr_last_addr = 6'h20; wr_last_msb = 0;
    rd(6'h20, 8'hFF, "R9 erase at last address");
    rd(6'h33, 8'hFF, "R9 erase other address");
    wr_busy = 0; tick("idle");

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 15) == 0) begin
        wr_busy = ~wr_busy;
      end
      wr_erase     = ($urandom_range(0, 3) == 0);
      wr_last_addr = AW'($urandom);
      wr_last_msb  = 1'($urandom);
      host_req     = ($urandom_range(0, 2) != 0);
      host_sel     = ($urandom_range(0, 5) != 0);
      host_oe      = ($urandom_range(0, 5) != 0);
      host_we      = ($urandom_range(0, 7) == 0);
      host_addr    = ($urandom_range(0, 2) == 0) ? m_addr : AW'($urandom);
      arr_rdata    = DW'($urandom) ^ DW'(first);
      tick("R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 random");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule